// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

This block is one bank of up to 32 general-purpose pins. Each pin can be driven as an output or read as an input. Software reaches all of the bank's state through a small register port that completes every access in one cycle. Writes take effect on the clock edge on which `bus_we` is high. Reads are combinational from `bus_addr`. The port has no valid/ready pair: every access finishes in its own cycle, so no back-pressure exists and none is needed.

Input pads pass through a two-flop synchroniser. Each pin then watches for an event of the kind software selected: a rising edge, a falling edge, a high level or a low level. An event sets a sticky pending bit, and that bit stays set until software writes a one to its position in the acknowledge register. The pending bits record events whether or not the pin is enabled. The enable mask only decides which pending bits reach the single registered interrupt line `irq`.

Register words, selected by `bus_addr`: 0 output data, 1 output enable, 2 synchronised pin levels (read-only), 3 detect mode (1 = edge, 0 = level), 4 polarity (1 = rising or high, 0 = falling or low), 5 interrupt enable, 6 acknowledge (write-one-to-clear, reads zero), 7 pending (read-only). Bit i of every word belongs to pin i.

Top module: `gpio_irq_bank`

## Requirements
- R1: A write to word 0 or word 1 appears on `pad_out` or `pad_oe` respectively after that clock edge. An enable bit of 1 drives the pin and 0 leaves it an input.
- R2: Word 2 returns the level of `pad_in` as seen through two flops. A change in `pad_in` is visible in the read two rising edges after it is applied, and not after one.
- R3: With mode 1, a pin whose polarity is 1 sets its pending bit on a 0-to-1 transition of its synchronised level. A pin whose polarity is 0 sets its pending bit on a 1-to-0 transition. A transition in the other direction sets nothing.
- R4: With mode 0, a pin sets its pending bit while its synchronised level equals its polarity bit. The bit stays set after the level goes away, until it is acknowledged.
- R5: Writing 1 to bit i of word 6 clears pending bit i. Writing 0 leaves it unchanged. Word 6 reads as zero.
- R6: Pending bits are set regardless of the enable word. A pending bit whose enable is 0 does not raise `irq`.
- R7: `irq` is a register that holds the OR over all pins of (pending AND enable) as it stood one cycle earlier.
- R8: Reset clears output data, output enable, interrupt enable, pending and `irq`, and sets mode and polarity to all ones (rising edge).
- R9: If an event and an acknowledge of the same pin fall on the same clock edge, the pending bit remains set.
- R10: Acknowledging a level-mode pin while its active level is still present leaves the pending bit reading 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 3 | Register word select |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data of the selected word |
| pad_in | input | NPINS | Pin levels from the pads, asynchronous |
| pad_out | output | NPINS | Output data to the pads |
| pad_oe | output | NPINS | Output enable per pin |
| irq | output | 1 | Registered summary interrupt |

## Verification
The bench builds the bank with NPINS = 12. That is a width other than the default, so any code that assumes 32 pins or a power-of-two width shows up, and the 12-bit vector keeps every bit easy to read in failure lines. With only 12 pins, random pad and register traffic soon reaches every mode and polarity combination on every pin. It also reaches acknowledges that land on the same edge as a new event, which a wider bank would hit only rarely.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RG_DOUT = 3'd0,
    RG_DIR  = 3'd1,
    RG_PINS = 3'd2,
    RG_MODE = 3'd3,
    RG_POL  = 3'd4,
    RG_IEN  = 3'd5,
    RG_ACK  = 3'd6,
    RG_PEND = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= async_in;
      stable_q <= meta_q;
    end
  end

  assign sync_out = stable_q;
endmodule

// File: rtl/gpio_event_det.sv
module gpio_event_det #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] edge_mode,
  input  logic [W-1:0] polarity,
  output logic [W-1:0] event_hit
);
  logic [W-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= level;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise_w, fall_w, act_w;
    assign rise_w = level[i] & ~last_q[i];
    assign fall_w = ~level[i] & last_q[i];
    assign act_w  = ~(level[i] ^ polarity[i]);
    always_comb begin
      if (edge_mode[i]) event_hit[i] = polarity[i] ? rise_w : fall_w;
      else              event_hit[i] = act_w;
    end
  end
endmodule

// File: rtl/gpio_csr.sv
module gpio_csr
  import gpio_bank_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  input  logic [W-1:0]      pins_lvl,
  input  logic [W-1:0]      pend_bits,
  output logic [W-1:0]      dout,
  output logic [W-1:0]      dir,
  output logic [W-1:0]      edge_mode,
  output logic [W-1:0]      polarity,
  output logic [W-1:0]      ien,
  output logic [W-1:0]      ack_mask
);
  reg_idx_e sel;
  assign sel = reg_idx_e'(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout      <= '0;
      dir       <= '0;
      edge_mode <= '1;
      polarity  <= '1;
      ien       <= '0;
    end else if (wr_en) begin
      case (sel)
        RG_DOUT: dout      <= wdata;
        RG_DIR:  dir       <= wdata;
        RG_MODE: edge_mode <= wdata;
        RG_POL:  polarity  <= wdata;
        RG_IEN:  ien       <= wdata;
        default: ;
      endcase
    end
  end

  assign ack_mask = (wr_en && sel == RG_ACK) ? wdata : '0;

  always_comb begin
    case (sel)
      RG_DOUT: rdata = dout;
      RG_DIR:  rdata = dir;
      RG_PINS: rdata = pins_lvl;
      RG_MODE: rdata = edge_mode;
      RG_POL:  rdata = polarity;
      RG_IEN:  rdata = ien;
      RG_PEND: rdata = pend_bits;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_pend_irq.sv
module gpio_pend_irq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] event_hit,
  input  logic [W-1:0] ack_mask,
  input  logic [W-1:0] ien,
  output logic [W-1:0] pend,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      irq  <= 1'b0;
    end else begin
      pend <= (pend & ~ack_mask) | event_hit;
      irq  <= |(pend & ien);
    end
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq
);
  logic [NPINS-1:0] lvl_sync, mode_q, pol_q, ien_q, ack_w, evt_w, pend_q;

  gpio_sync2 #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(lvl_sync)
  );

  gpio_event_det #(.W(NPINS)) u_det (
    .clk(clk), .rst_n(rst_n), .level(lvl_sync), .edge_mode(mode_q),
    .polarity(pol_q), .event_hit(evt_w)
  );

  gpio_csr #(.W(NPINS)) u_csr (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .pins_lvl(lvl_sync),
    .pend_bits(pend_q), .dout(pad_out), .dir(pad_oe), .edge_mode(mode_q),
    .polarity(pol_q), .ien(ien_q), .ack_mask(ack_w)
  );

  gpio_pend_irq #(.W(NPINS)) u_pend (
    .clk(clk), .rst_n(rst_n), .event_hit(evt_w), .ack_mask(ack_w),
    .ien(ien_q), .pend(pend_q), .irq(irq)
  );
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [REG_AW-1:0] bus_addr,
  input logic [NPINS-1:0]  bus_wdata,
  input logic [NPINS-1:0]  pad_oe,
  input logic              irq,
  input logic [NPINS-1:0]  pend,
  input logic [NPINS-1:0]  ien,
  input logic [NPINS-1:0]  evt
);
  logic [NPINS-1:0] clr_req;
  assign clr_req = (bus_we && bus_addr == RG_ACK) ? bus_wdata : '0;

  AST_OE_TRACKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == RG_DIR) |=> (pad_oe == $past(bus_wdata))); // R1
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~pend & $past(pend) & ~$past(clr_req)) == '0)); // R4
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(evt)) == $past(evt))); // R9
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend & ien)) |=> irq); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(pend & ien)) |=> !irq); // R6
  AST_IEN_RESET: assert property (@(posedge clk)
    !rst_n |=> (ien == '0)); // R8
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pad_oe(pad_oe), .irq(irq), .pend(pend_q),
  .ien(ien_q), .evt(evt_w)
);

// File: tb/gpio_irq_bank_bench.sv
`timescale 1ns/1ps
module gpio_irq_bank_bench;
  localparam int N = 12;
  localparam logic [N-1:0] ALL1 = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [N-1:0] bus_wdata = '0;
  logic [N-1:0] bus_rdata;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_out, pad_oe;
  logic irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [N-1:0] m_s1, m_s2, m_prev, m_dout, m_dir, m_mode, m_pol, m_ien, m_pend;
  logic m_irq;

  always #2.5 clk = ~clk;

  gpio_irq_bank #(.NPINS(N)) u_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  function automatic logic [N-1:0] exp_event(logic [N-1:0] lv, logic [N-1:0] pv,
                                              logic [N-1:0] md, logic [N-1:0] pl);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      if (md[i]) r[i] = pl[i] ? (lv[i] && !pv[i]) : (!lv[i] && pv[i]);
      else       r[i] = (lv[i] == pl[i]);
    end
    return r;
  endfunction

  function automatic logic [N-1:0] exp_read(logic [2:0] a);
    case (a)
      3'd0: return m_dout;
      3'd1: return m_dir;
      3'd2: return m_s2;
      3'd3: return m_mode;
      3'd4: return m_pol;
      3'd5: return m_ien;
      3'd7: return m_pend;
      default: return '0;
    endcase
  endfunction

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_s1 = '0; m_s2 = '0; m_prev = '0; m_dout = '0; m_dir = '0;
    m_mode = ALL1; m_pol = ALL1; m_ien = '0; m_pend = '0; m_irq = 1'b0;
  endtask

  // one clock edge; inputs already stable
  task automatic tick();
    logic [N-1:0] ev, ack, nxt_pend;
    logic nxt_irq;
    ev = exp_event(m_s2, m_prev, m_mode, m_pol);
    ack = (bus_we && bus_addr == 3'd6) ? bus_wdata : '0;
    nxt_pend = (m_pend & ~ack) | ev;
    nxt_irq = |(m_pend & m_ien);
    @(posedge clk);
    #1;
    m_prev = m_s2; m_s2 = m_s1; m_s1 = pad_in;
    m_pend = nxt_pend; m_irq = nxt_irq;
    if (bus_we) begin
      case (bus_addr)
        3'd0: m_dout = bus_wdata;
        3'd1: m_dir  = bus_wdata;
        3'd3: m_mode = bus_wdata;
        3'd4: m_pol  = bus_wdata;
        3'd5: m_ien  = bus_wdata;
        default: ;
      endcase
    end
    chk("R1 pad_out", pad_out, m_dout);
    chk("R1 pad_oe", pad_oe, m_dir);
    chk("R7 irq", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, m_irq});
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [N-1:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic rd(string tag, logic [2:0] a);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp_read(a));
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R8 reset state
    chk("R8 irq", {{(N-1){1'b0}}, irq}, '0);
    bus_addr = 3'd5; #1; chk("R8 ien", bus_rdata, '0);
    bus_addr = 3'd7; #1; chk("R8 pend", bus_rdata, '0);
    bus_addr = 3'd3; #1; chk("R8 mode", bus_rdata, ALL1);
    bus_addr = 3'd1; #1; chk("R8 oe", bus_rdata, '0);
    // R1 drive pads
    wr(3'd0, 12'h0A5);
    wr(3'd1, 12'hF0F);
    chk("R1 out const", pad_out, 12'h0A5);
    chk("R1 oe const", pad_oe, 12'hF0F);
    // R2 synchroniser latency
    pad_in = 12'h03C;
    tick(); rd("R2 one edge", 3'd2); chk("R2 not yet", bus_rdata, '0);
    tick(); rd("R2 two edges", 3'd2); chk("R2 level", bus_rdata, 12'h03C);
    ticks(2);
    rd("R3 rising pend", 3'd7); chk("R3 rising const", bus_rdata, 12'h03C);
    // R5 acknowledge
    wr(3'd6, 12'h000); rd("R5 zero write", 3'd7); chk("R5 no effect", bus_rdata, 12'h03C);
    wr(3'd6, ALL1); rd("R5 cleared", 3'd7); chk("R5 cleared const", bus_rdata, '0);
    rd("R5 ack reads zero", 3'd6);
    // R3 falling on pin 2, rising direction ignored on pin 2
    wr(3'd4, 12'hFFB);
    pad_in = 12'h038; ticks(3);
    rd("R3 falling", 3'd7); chk("R3 falling const", bus_rdata, 12'h004);
    wr(3'd6, 12'h004);
    pad_in = 12'h03C; ticks(4);
    rd("R3 wrong dir", 3'd7); chk("R3 wrong dir const", bus_rdata, '0);
    pad_in = 12'h038; ticks(3);
    // R6 pending without enable, then enable
    chk("R6 masked irq", {{(N-1){1'b0}}, irq}, '0);
    rd("R6 pend set", 3'd7); chk("R6 pend const", bus_rdata, 12'h004);
    wr(3'd5, 12'h004); tick();
    chk("R7 irq up", {{(N-1){1'b0}}, irq}, 12'h001);
    wr(3'd6, 12'h004); tick();
    chk("R7 irq down", {{(N-1){1'b0}}, irq}, '0);
    // R4 level high latched on pin 8
    wr(3'd3, 12'hEFF);
    pad_in = 12'h138; ticks(4);
    pad_in = 12'h038; ticks(4);
    rd("R4 sticky", 3'd7); chk("R4 sticky const", bus_rdata & 12'h100, 12'h100);
    // R10 level still active on pin 9 at acknowledge
    wr(3'd6, ALL1);
    wr(3'd3, 12'hCFF);
    pad_in = 12'h238; ticks(4);
    wr(3'd6, 12'h200);
    rd("R10 re-set", 3'd7); chk("R10 const", bus_rdata & 12'h200, 12'h200);
    pad_in = 12'h038; ticks(3);
    wr(3'd6, ALL1);
    // R9 event on pin 3 lands on the acknowledge edge
    pad_in = 12'h030; ticks(4);
    wr(3'd6, ALL1);
    pad_in = 12'h038;
    ticks(2);
    wr(3'd6, 12'h008);
    rd("R9 event wins", 3'd7); chk("R9 const", bus_rdata & 12'h008, 12'h008);
    // random traffic
    for (int c = 0; c < 4000; c++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[2:0] == 3'd0) pad_in = N'($urandom);
      bus_we = (r[5:3] < 3'd3);
      bus_addr = r[8:6];
      bus_wdata = N'($urandom);
      tick();
      bus_we = 1'b0;
      rd("R3 R4 R5 random read", N'(0) == 0 ? r[11:9] : 3'd0);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule